// File: doc/BRIEF.md
# Low-voltage supervisor control register

This block is the digital control and status logic around an on-chip supply monitor. The monitor has two parts: a low-voltage detector that software can poll, and a low-voltage reset that acts like the external reset pin. Two static build options choose which parts exist. One 8-bit register, written over a simple bus, holds a runtime detector enable, a three-bit real-time clock prescaler tap select and one general read/write bit. The block reads the same register back together with a latched detection flag.

From the two options and the runtime enable, a fixed priority table derives three enables: one for the shared voltage reference, one for the reset comparator and one for the detect comparator. The reset comparator enable is forced low while the chip is in HALT. The analog comparator outputs arrive as asynchronous digital levels. They pass through synchronizers. The reset path then feeds a hold counter that stretches the chip reset request. The reset input `rst` is synchronous and active high.

Top module: `lvsup_ctrl`

## Requirements
- R1: During and after `rst` the register reads 0x00. `tap_sel`, `lvd_status` and `chip_rst_req` are 0, and the enables follow the table with the runtime bit at 0.
- R2: A cycle with `wr_en`=1 and `addr`=REG_ADDR (default 9) stores `wdata` bits 4:0 at the rising edge. Bits 2:0 are the tap select driven on `tap_sel`, bit 3 is the runtime detector enable and bit 4 is a plain read/write bit. A write to any other address, or a cycle without `wr_en`, leaves the register unchanged.
- R3: `rdata` shows the register combinationally: bits 4:0 are the stored bits, bit 5 is `lvd_status`, and bits 7:6 always read 0.
- R4: With both options set, `ref_en`=1 and `lvr_cmp_en`=1 (outside HALT). `lvd_cmp_en` equals the runtime bit.
- R5: With only the detect option set, `ref_en` and `lvd_cmp_en` both equal the runtime bit, and `lvr_cmp_en`=0.
- R6: With only the reset option set, `ref_en`=1, `lvr_cmp_en`=1 (outside HALT) and `lvd_cmp_en`=0 for either runtime bit. With neither option set, all three enables are 0.
- R7: While `halt`=1, `lvr_cmp_en` is 0 and no new reset request starts. `ref_en` and `lvd_cmp_en` are unaffected by `halt`.
- R8: While `lvd_cmp_en`=1, `lvd_status` takes the synchronized `lvd_cmp_in` on every edge. One edge after `lvd_cmp_en` is 0, it reads 0. Writing bit 5 has no effect.
- R9: When `lvr_cmp_in` rises while `lvr_cmp_en`=1, `chip_rst_req` rises after SYNC_STAGES+1 rising edges (3 by default).
- R10: After `lvr_cmp_in` falls, `chip_rst_req` stays high for SYNC_STAGES+HOLD_CYCLES edges and drops on the following edge (the 19th by default). This guarantees at least HOLD_CYCLES cycles of hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opt_detect_en | input | 1 | Static build option: detector present |
| opt_reset_en | input | 1 | Static build option: low-voltage reset present |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, unused bits 0 |
| halt | input | 1 | Chip in HALT |
| lvr_cmp_in | input | 1 | Reset comparator output (asynchronous) |
| lvd_cmp_in | input | 1 | Detect comparator output (asynchronous) |
| ref_en | output | 1 | Voltage reference enable |
| lvr_cmp_en | output | 1 | Reset comparator enable |
| lvd_cmp_en | output | 1 | Detect comparator enable |
| lvd_status | output | 1 | Latched detection flag |
| tap_sel | output | 3 | Prescaler tap select |
| chip_rst_req | output | 1 | Chip reset request |

## Verification
The bench builds the block with its defaults: ADDR_W=4, REG_ADDR=9, SYNC_STAGES=2 and HOLD_CYCLES=16. With these values the full reset stretch is a 19-edge window, so the exact release edge can be counted cycle by cycle. The 4-bit address space is small, so random writes hit both the decoded address and neighbouring ones. All eight combinations of the two options and the runtime bit are reached, with and without HALT, and each is checked against a table computed in the bench.

// File: rtl/lvsup_pkg.sv
package lvsup_pkg;

    localparam int DATA_W = 8;

    // Register image, most significant field first
    typedef struct packed {
        logic [1:0] spare;
        logic       status;
        logic       aux;
        logic       run_en;
        logic [2:0] tap;
    } ctrl_reg_t;

    typedef struct packed {
        logic ref_on;
        logic rst_cmp_on;
        logic det_cmp_on;
    } supply_en_t;

    typedef enum logic [1:0] {
        MODE_NONE     = 2'b00,
        MODE_RST_ONLY = 2'b01,
        MODE_DET_ONLY = 2'b10,
        MODE_BOTH     = 2'b11
    } opt_mode_e;

    function automatic opt_mode_e mode_of(input logic det_opt, input logic rst_opt);
        return opt_mode_e'({det_opt, rst_opt});
    endfunction

    // Priority table: build options first, runtime bit second
    function automatic supply_en_t en_lookup(input opt_mode_e mode, input logic run);
        supply_en_t e;
        e = '0;
        case (mode)
            MODE_BOTH: begin
                e.ref_on     = 1'b1;
                e.rst_cmp_on = 1'b1;
                e.det_cmp_on = run;
            end
            MODE_DET_ONLY: begin
                e.ref_on     = run;
                e.rst_cmp_on = 1'b0;
                e.det_cmp_on = run;
            end
            MODE_RST_ONLY: begin
                e.ref_on     = 1'b1;
                e.rst_cmp_on = 1'b1;
                e.det_cmp_on = 1'b0;
            end
            default: e = '0;
        endcase
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] read_view(input ctrl_reg_t r);
        ctrl_reg_t v;
        v       = r;
        v.spare = 2'b00;
        return v;
    endfunction

endpackage

// File: rtl/lvsup_sync.sv
module lvsup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lvsup_ctrl_reg.sv
module lvsup_ctrl_reg
    import lvsup_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              det_on,
    input  logic              det_level,
    output logic [DATA_W-1:0] rdata,
    output logic [2:0]        tap,
    output logic              run_en,
    output logic              status
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    ctrl_reg_t cur;
    ctrl_reg_t wimg;
    logic      hit;

    assign wimg = ctrl_reg_t'(wdata);
    assign hit  = wr_en && (addr == HIT_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            if (hit) begin
                cur.tap    <= wimg.tap;
                cur.run_en <= wimg.run_en;
                cur.aux    <= wimg.aux;
            end
            // status is hardware-owned: software data never reaches it
            cur.status <= det_on & det_level;
            cur.spare  <= 2'b00;
        end
    end

    assign rdata  = read_view(cur);
    assign tap    = cur.tap;
    assign run_en = cur.run_en;
    assign status = cur.status;
endmodule

// File: rtl/lvsup_rst_hold.sv
module lvsup_rst_hold #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic req
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            req    <= 1'b0;
        end else begin
            req <= active || (remain != '0);
            if (active)
                remain <= CNT_W'(HOLD_CYCLES);
            else if (remain != '0)
                remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/lvsup_ctrl.sv
module lvsup_ctrl
    import lvsup_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int REG_ADDR    = 9,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              opt_detect_en,
    input  logic              opt_reset_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              halt,
    input  logic              lvr_cmp_in,
    input  logic              lvd_cmp_in,
    output logic              ref_en,
    output logic              lvr_cmp_en,
    output logic              lvd_cmp_en,
    output logic              lvd_status,
    output logic [2:0]        tap_sel,
    output logic              chip_rst_req
);
    logic       run_bit;
    logic       det_sync;
    logic       rst_sync;
    logic       lvr_active;
    supply_en_t table_en;

    assign table_en   = en_lookup(mode_of(opt_detect_en, opt_reset_en), run_bit);
    assign ref_en     = table_en.ref_on;
    assign lvd_cmp_en = table_en.det_cmp_on;
    assign lvr_cmp_en = table_en.rst_cmp_on & ~halt;
    assign lvr_active = lvr_cmp_en & rst_sync;

    lvsup_sync #(.STAGES(SYNC_STAGES)) u_det_sync (
        .clk (clk),
        .rst (rst),
        .d   (lvd_cmp_in),
        .q   (det_sync)
    );

    lvsup_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk (clk),
        .rst (rst),
        .d   (lvr_cmp_in),
        .q   (rst_sync)
    );

    lvsup_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .det_on    (table_en.det_cmp_on),
        .det_level (det_sync),
        .rdata     (rdata),
        .tap       (tap_sel),
        .run_en    (run_bit),
        .status    (lvd_status)
    );

    lvsup_rst_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .active (lvr_active),
        .req    (chip_rst_req)
    );
endmodule

// File: rtl/lvsup_ctrl_chk.sv
module lvsup_ctrl_chk #(
    parameter int ADDR_W      = 4,
    parameter int REG_ADDR    = 9,
    parameter int HOLD_CYCLES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              opt_detect_en,
    input logic              opt_reset_en,
    input logic              halt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input logic              ref_en,
    input logic              lvr_cmp_en,
    input logic              lvd_cmp_en,
    input logic              lvd_status,
    input logic [2:0]        tap_sel,
    input logic              chip_rst_req,
    input logic              lvr_active
);
    localparam int QW = $clog2(HOLD_CYCLES + 2) + 1;
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    logic          rst_seen = 1'b0;
    logic [QW-1:0] quiet;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst || lvr_active)
            quiet <= '0;
        else if (quiet != {QW{1'b1}})
            quiet <= quiet + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst_seen && !rst)
            assert_reset_clear_R1: assert (rdata == 8'h00 && !chip_rst_req && tap_sel == 3'd0);
    end

    assert_other_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || addr != HIT_ADDR) |=> $stable(rdata[4:0]));

    assert_spare_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rdata[7:6] == 2'b00 && rdata[5] == lvd_status && rdata[2:0] == tap_sel);

    assert_both_opts_R4: assert property (@(posedge clk) disable iff (rst)
        (opt_detect_en && opt_reset_en) |-> (ref_en && lvr_cmp_en == !halt && lvd_cmp_en == rdata[3]));

    assert_det_only_R5: assert property (@(posedge clk) disable iff (rst)
        (opt_detect_en && !opt_reset_en) |-> (!lvr_cmp_en && ref_en == rdata[3] && lvd_cmp_en == rdata[3]));

    assert_no_det_opt_R6: assert property (@(posedge clk) disable iff (rst)
        !opt_detect_en |-> (!lvd_cmp_en && ref_en == opt_reset_en));

    assert_halt_gate_R7: assert property (@(posedge clk) disable iff (rst)
        halt |-> !lvr_cmp_en);

    assert_status_off_R8: assert property (@(posedge clk) disable iff (rst)
        !lvd_cmp_en |=> !lvd_status);

    assert_req_follows_R9: assert property (@(posedge clk) disable iff (rst)
        lvr_active |=> chip_rst_req);

    assert_hold_min_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_rst_req) |-> (quiet >= QW'(HOLD_CYCLES)));
endmodule

bind lvsup_ctrl lvsup_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .REG_ADDR    (REG_ADDR),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .opt_detect_en (opt_detect_en),
    .opt_reset_en  (opt_reset_en),
    .halt          (halt),
    .wr_en         (wr_en),
    .addr          (addr),
    .rdata         (rdata),
    .ref_en        (ref_en),
    .lvr_cmp_en    (lvr_cmp_en),
    .lvd_cmp_en    (lvd_cmp_en),
    .lvd_status    (lvd_status),
    .tap_sel       (tap_sel),
    .chip_rst_req  (chip_rst_req),
    .lvr_active    (lvr_active)
);

// File: tb/lvsup_ctrl_bench.sv
`timescale 1ns/1ps
module lvsup_ctrl_bench;
    localparam int ADDR_W = 4;
    localparam int REG_A  = 9;
    localparam int SYNC   = 2;
    localparam int HOLD   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              opt_detect_en = 1'b0;
    logic              opt_reset_en  = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr  = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic              halt = 1'b0;
    logic              lvr_cmp_in = 1'b0;
    logic              lvd_cmp_in = 1'b0;
    logic              ref_en, lvr_cmp_en, lvd_cmp_en, lvd_status, chip_rst_req;
    logic [2:0]        tap_sel;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    lvsup_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_A), .SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) u_lvsup_ctrl (
        .clk(clk), .rst(rst), .opt_detect_en(opt_detect_en), .opt_reset_en(opt_reset_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .halt(halt),
        .lvr_cmp_in(lvr_cmp_in), .lvd_cmp_in(lvd_cmp_in), .ref_en(ref_en),
        .lvr_cmp_en(lvr_cmp_en), .lvd_cmp_en(lvd_cmp_en), .lvd_status(lvd_status),
        .tap_sel(tap_sel), .chip_rst_req(chip_rst_req)
    );

    // expected {ref, lvr, lvd} from the requirement table
    function automatic logic [2:0] exp_en(input logic det, input logic rop, input logic run, input logic h);
        logic r, l, d;
        d = det & run;
        l = rop & ~h;
        r = rop | (det & run);
        return {r, l, d};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] shadow;
        logic [7:0] d;
        logic [ADDR_W-1:0] a;
        void'($urandom(32'h5EED_1234));

        step(3);
        #1;
        chk("R1 rdata in reset", rdata, 8'h00);
        chk("R1 req in reset", chip_rst_req, 1'b0);
        rst = 1'b0;
        step(1); #1;
        chk("R1 rdata after reset", rdata, 8'h00);
        chk("R1 tap after reset", tap_sel, 3'd0);
        chk("R1 status after reset", lvd_status, 1'b0);
        chk("R1 enables after reset", {ref_en, lvr_cmp_en, lvd_cmp_en}, exp_en(1'b0, 1'b0, 1'b0, 1'b0));

        // random register and enable table coverage
        shadow = 8'h00;
        for (int i = 0; i < 300; i++) begin
            opt_detect_en = 1'($urandom);
            opt_reset_en  = 1'($urandom);
            halt          = 1'($urandom);
            d = 8'($urandom);
            a = ($urandom % 3 == 0) ? ADDR_W'(REG_A) : ADDR_W'($urandom);
            wr(a, d);
            if (a == ADDR_W'(REG_A)) shadow = d & 8'h1F;
            chk("R2 R3 readback", rdata, shadow);
            chk("R2 tap", tap_sel, shadow[2:0]);
            if (opt_detect_en && opt_reset_en)
                chk("R4 enable table", {ref_en, lvr_cmp_en, lvd_cmp_en}, exp_en(1'b1, 1'b1, shadow[3], halt));
            else if (opt_detect_en)
                chk("R5 enable table", {ref_en, lvr_cmp_en, lvd_cmp_en}, exp_en(1'b1, 1'b0, shadow[3], halt));
            else
                chk("R6 enable table", {ref_en, lvr_cmp_en, lvd_cmp_en}, exp_en(1'b0, opt_reset_en, shadow[3], halt));
            if (halt) chk("R7 halt gate", lvr_cmp_en, 1'b0);
        end
        halt = 1'b0;

        // directed: unused bits and bit 5 written as ones
        opt_detect_en = 1'b1; opt_reset_en = 1'b0;
        wr(ADDR_W'(REG_A), 8'hE7);
        chk("R3 unused bits read zero", rdata, 8'h07);
        wr(ADDR_W'(REG_A + 1), 8'h1A);
        chk("R2 neighbour address ignored", rdata, 8'h07);

        // detection status
        lvd_cmp_in = 1'b1;
        wr(ADDR_W'(REG_A), 8'h08);
        step(4);
        chk("R8 status follows input", lvd_status, 1'b1);
        chk("R3 status in rdata", rdata, 8'h28);
        wr(ADDR_W'(REG_A), 8'h08);
        chk("R8 write of bit5=0 ignored", lvd_status, 1'b1);
        lvd_cmp_in = 1'b0;
        step(4);
        chk("R8 status follows low", lvd_status, 1'b0);
        wr(ADDR_W'(REG_A), 8'h28);
        step(1);
        chk("R8 write of bit5=1 ignored", lvd_status, 1'b0);
        lvd_cmp_in = 1'b1;
        wr(ADDR_W'(REG_A), 8'h00);
        step(4);
        chk("R8 status cleared when disabled", lvd_status, 1'b0);
        opt_detect_en = 1'b0;
        wr(ADDR_W'(REG_A), 8'h08);
        step(4);
        chk("R5 detect option off blocks comparator", lvd_cmp_en, 1'b0);
        chk("R8 status off without option", lvd_status, 1'b0);
        lvd_cmp_in = 1'b0;

        // reset request timing
        opt_reset_en = 1'b1;
        lvr_cmp_in = 1'b1;
        step(SYNC);
        chk("R9 no request before sync delay", chip_rst_req, 1'b0);
        step(1);
        chk("R9 request after sync delay", chip_rst_req, 1'b1);
        step(5);
        lvr_cmp_in = 1'b0;
        for (int k = 1; k <= SYNC + HOLD; k++) begin
            step(1);
            chk("R10 request held", chip_rst_req, 1'b1);
        end
        step(1);
        chk("R10 request released", chip_rst_req, 1'b0);

        // halt blocks new requests
        halt = 1'b1;
        lvr_cmp_in = 1'b1;
        step(25);
        chk("R7 no request in halt", chip_rst_req, 1'b0);
        chk("R7 ref unaffected by halt", ref_en, 1'b1);
        halt = 1'b0;
        step(SYNC + 2);
        chk("R9 request after halt ends", chip_rst_req, 1'b1);
        lvr_cmp_in = 1'b0;
        step(SYNC + HOLD + 2);

        // reset option off
        opt_reset_en = 1'b0;
        lvr_cmp_in = 1'b1;
        step(25);
        chk("R6 no request without option", chip_rst_req, 1'b0);
        lvr_cmp_in = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule